// File: doc/BRIEF.md
# Bit-Oriented Message Receive Filter

This block sits on the receive side of a T1 facility data link. It takes the serial bit stream one bit at a time and finds 16-bit bit-oriented message codewords in it. Each codeword starts with eight ones and a zero. Six message bits follow, and a closing zero ends the codeword. With filtering on, a message counts as valid only when at least 7 of the last 10 codeword slots carry the same message. When that happens the block writes the codeword and a status byte to a receive FIFO write port. It then pulses a message-end interrupt and sets a level flag that shows a valid message is present.

The flag stays set while the validated message keeps its majority in the window. When the majority is lost, the flag clears and a separate message-invalid interrupt pulses. A codeword with a bad closing bit counts as a slot that matches nothing. So does every run of 16 hunting bits that contains no sync. This lets a vanished or corrupted pattern age out of the window.

With filtering off, the majority vote is skipped. Every correctly framed codeword goes to the FIFO as it arrives, and the flag is held low. The window keeps recording in both modes.

Top module: `bom_filter`

## Requirements
- R1: After reset, fifo_wr_o, rme_irq_o, biv_irq_o and bom_valid_o are all 0.
- R2: Only bits with bit_vld_i high are taken. A codeword is the bit sequence 11111111, 0, m5..m0, 0, sent first bit first. The six message bits m5..m0 form the message code, with m5 as its most significant bit.
- R3: With filt_en_i high, a message code is accepted when, counting the new codeword, at least 7 of the last 10 codeword slots carry it. On acceptance, three bytes are written on consecutive cycles: 8'hFF, then {1'b0, m5..m0, 1'b0}, then the status byte 8'h01, whose bit 0 marks a BOM frame.
- R4: rme_irq_o pulses for one cycle, in the same cycle as the status byte write.
- R5: bom_valid_o rises on acceptance. It stays high while at least 7 of the last 10 slots carry the accepted code.
- R6: Further repeats of a held code cause no FIFO write.
- R7: When fewer than 7 of the last 10 slots carry the held code, bom_valid_o clears and biv_irq_o pulses for one cycle.
- R8: A codeword whose closing bit is 1 fills one slot that matches nothing and writes nothing. So does each run of 16 taken bits that holds no sync.
- R9: With filt_en_i low, every correctly framed codeword is written at once as in R3, with its rme_irq_o pulse. bom_valid_o is held at 0 and biv_irq_o stays 0.
- R10: The first byte is written in the second cycle after the clock edge that takes the closing bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received data link bit |
| bit_vld_i | input | 1 | bit_i carries a new bit this cycle |
| filt_en_i | input | 1 | 1: 7-of-10 filtering, 0: pass every framed codeword |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write byte |
| rme_irq_o | output | 1 | Message-end interrupt pulse |
| biv_irq_o | output | 1 | Message-invalid interrupt pulse |
| bom_valid_o | output | 1 | A validated message is currently held |

## Verification
The assertions check the following on every cycle:
- The three-byte write sequence keeps its order, and the second byte has zero guard bits.
- The message-end pulse coincides with the status byte.
- A rise of the valid flag coincides with the start of a write.
- A fall of the flag while filtering is on always raises the invalid pulse, and that pulse is single.
- The flag stays low while filtering is off.

Only the bench scenarios can show that the 7-of-10 count is right across mixed streams. The same holds for whether held repeats are suppressed, whether bad closing bits and sync-less idle fill slots, and which message bits end up in the written byte. The bench compares each codeword's effect with a window model of its own.

// File: rtl/bom_pkg.sv
package bom_pkg;
  localparam int          CODE_W    = 6;
  localparam logic [7:0]  SYNC_BYTE = 8'hFF;
  localparam logic [7:0]  STAT_BOM  = 8'h01;     // bit 0: frame type BOM
  localparam logic [8:0]  SYNC_PAT  = 9'h1FE;    // eight ones then a zero
endpackage

// File: rtl/bom_framer.sv
module bom_framer
  import bom_pkg::*;
#(
  parameter int MISS_BITS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_vld_i,
  output logic              ev_o,
  output logic              ev_miss_o,
  output logic [CODE_W-1:0] ev_code_o
);
  localparam int CNT_W = $clog2(CODE_W + 1);
  localparam int HNT_W = $clog2(MISS_BITS + 1);

  typedef enum logic {S_HUNT, S_BODY} st_e;

  st_e               st_q;
  logic [8:0]        sr_q;
  logic [8:0]        sr_nxt;
  logic [CNT_W-1:0]  body_cnt_q;
  logic [HNT_W-1:0]  hunt_q;
  logic [CODE_W-1:0] msg_q;
  logic              ev_q, miss_q;
  logic [CODE_W-1:0] code_q;

  assign sr_nxt = {sr_q[7:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_HUNT;
      sr_q       <= '0;
      body_cnt_q <= '0;
      hunt_q     <= '0;
      msg_q      <= '0;
      ev_q       <= 1'b0;
      miss_q     <= 1'b0;
      code_q     <= '0;
    end else begin
      ev_q <= 1'b0;
      if (bit_vld_i) begin
        unique case (st_q)
          S_HUNT: begin
            if (sr_nxt == SYNC_PAT) begin
              st_q       <= S_BODY;
              body_cnt_q <= '0;
              hunt_q     <= '0;
              sr_q       <= '0;
            end else begin
              sr_q <= sr_nxt;
              // a run of hunting bits with no sync fills one empty slot
              if (hunt_q == HNT_W'(MISS_BITS - 1)) begin
                hunt_q <= '0;
                ev_q   <= 1'b1;
                miss_q <= 1'b1;
              end else begin
                hunt_q <= hunt_q + 1'b1;
              end
            end
          end
          S_BODY: begin
            if (body_cnt_q == CNT_W'(CODE_W)) begin
              st_q   <= S_HUNT;
              ev_q   <= 1'b1;
              miss_q <= bit_i;          // closing bit must be zero
              code_q <= msg_q;
            end else begin
              msg_q      <= {msg_q[CODE_W-2:0], bit_i};
              body_cnt_q <= body_cnt_q + 1'b1;
            end
          end
          default: st_q <= S_HUNT;
        endcase
      end
    end
  end

  assign ev_o      = ev_q;
  assign ev_miss_o = miss_q;
  assign ev_code_o = code_q;
endmodule

// File: rtl/bom_window.sv
module bom_window
  import bom_pkg::*;
#(
  parameter int WIN = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       miss_i,
  input  logic [CODE_W-1:0]          code_i,
  input  logic [CODE_W-1:0]          ref_i,
  output logic [$clog2(WIN+1)-1:0]   new_hits_o,
  output logic [$clog2(WIN+1)-1:0]   ref_hits_o
);
  localparam int HW = $clog2(WIN + 1);

  logic [CODE_W-1:0] slot_code_q [WIN];
  logic [WIN-1:0]    slot_ok_q;

  // counts over the window as it stands after this push
  always_comb begin
    new_hits_o = miss_i ? '0 : HW'(1);
    ref_hits_o = (!miss_i && code_i == ref_i) ? HW'(1) : '0;
    for (int i = 0; i < WIN - 1; i++) begin
      if (!miss_i && slot_ok_q[i] && slot_code_q[i] == code_i)
        new_hits_o = new_hits_o + HW'(1);
      if (slot_ok_q[i] && slot_code_q[i] == ref_i)
        ref_hits_o = ref_hits_o + HW'(1);
    end
  end

  for (genvar g = 0; g < WIN; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_code_q[g] <= '0;
        slot_ok_q[g]   <= 1'b0;
      end else if (push_i) begin
        if (g == 0) begin
          slot_code_q[g] <= code_i;
          slot_ok_q[g]   <= !miss_i;
        end else begin
          slot_code_q[g] <= slot_code_q[g-1];
          slot_ok_q[g]   <= slot_ok_q[g-1];
        end
      end
    end
  end
endmodule

// File: rtl/bom_writer.sv
module bom_writer
  import bom_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              wr_o,
  output logic [7:0]        data_o,
  output logic              rme_o
);
  logic [1:0]        ph_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 2'd0;
      code_q <= '0;
      wr_o   <= 1'b0;
      data_o <= '0;
      rme_o  <= 1'b0;
    end else begin
      rme_o <= 1'b0;
      unique case (ph_q)
        2'd0: begin
          if (start_i) begin
            wr_o   <= 1'b1;
            data_o <= SYNC_BYTE;
            code_q <= code_i;
            ph_q   <= 2'd1;
          end else begin
            wr_o <= 1'b0;
          end
        end
        2'd1: begin
          data_o <= {1'b0, code_q, 1'b0};
          ph_q   <= 2'd2;
        end
        2'd2: begin
          data_o <= STAT_BOM;
          rme_o  <= 1'b1;
          ph_q   <= 2'd0;
        end
        default: ph_q <= 2'd0;
      endcase
    end
  end
endmodule

// File: rtl/bom_filter.sv
module bom_filter
  import bom_pkg::*;
#(
  parameter int WIN       = 10,
  parameter int THRESH    = 7,
  parameter int MISS_BITS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  input  logic       filt_en_i,
  output logic       fifo_wr_o,
  output logic [7:0] fifo_data_o,
  output logic       rme_irq_o,
  output logic       biv_irq_o,
  output logic       bom_valid_o
);
  localparam int HW = $clog2(WIN + 1);

  logic              ev, ev_miss;
  logic [CODE_W-1:0] ev_code;
  logic [HW-1:0]     new_hits, ref_hits;
  logic              valid_q, biv_q;
  logic [CODE_W-1:0] vcode_q;
  logic              held_ok, accept, start;

  bom_framer #(.MISS_BITS(MISS_BITS)) u_framer (
    .clk_i, .rst_ni, .bit_i, .bit_vld_i,
    .ev_o(ev), .ev_miss_o(ev_miss), .ev_code_o(ev_code)
  );

  bom_window #(.WIN(WIN)) u_window (
    .clk_i, .rst_ni,
    .push_i(ev), .miss_i(ev_miss), .code_i(ev_code), .ref_i(vcode_q),
    .new_hits_o(new_hits), .ref_hits_o(ref_hits)
  );

  assign held_ok = valid_q && (ref_hits >= HW'(THRESH));
  assign accept  = filt_en_i && ev && !ev_miss && !held_ok
                   && (new_hits >= HW'(THRESH));
  assign start   = ev && !ev_miss && (!filt_en_i || accept);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vcode_q <= '0;
      biv_q   <= 1'b0;
    end else begin
      biv_q <= 1'b0;
      if (!filt_en_i) begin
        valid_q <= 1'b0;
      end else if (ev) begin
        if (valid_q && !held_ok) biv_q <= 1'b1;
        if (accept) begin
          valid_q <= 1'b1;
          vcode_q <= ev_code;
        end else if (valid_q && !held_ok) begin
          valid_q <= 1'b0;
        end
      end
    end
  end

  bom_writer u_writer (
    .clk_i, .rst_ni, .start_i(start), .code_i(ev_code),
    .wr_o(fifo_wr_o), .data_o(fifo_data_o), .rme_o(rme_irq_o)
  );

  assign bom_valid_o = valid_q;
  assign biv_irq_o   = biv_q;
endmodule

// File: rtl/bom_filter_chk.sv
module bom_filter_chk
  import bom_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       filt_en_i,
  input logic       fifo_wr_o,
  input logic [7:0] fifo_data_o,
  input logic       rme_irq_o,
  input logic       biv_irq_o,
  input logic       bom_valid_o
);
  assert_rme_on_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rme_irq_o |-> (fifo_wr_o && fifo_data_o == STAT_BOM));

  assert_body_after_sync_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && fifo_data_o == SYNC_BYTE) |=>
      (fifo_wr_o && !fifo_data_o[7] && !fifo_data_o[0]));

  assert_status_after_body_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr_o && $past(fifo_wr_o) && $past(fifo_data_o) == SYNC_BYTE) |=>
      (fifo_wr_o && fifo_data_o == STAT_BOM && rme_irq_o));

  assert_valid_rise_writes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bom_valid_o) |-> (fifo_wr_o && fifo_data_o == SYNC_BYTE));

  assert_biv_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    biv_irq_o |-> $past(bom_valid_o));

  assert_fall_raises_biv_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bom_valid_o) && $past(filt_en_i)) |-> biv_irq_o);

  assert_biv_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    biv_irq_o |=> !biv_irq_o);

  assert_off_holds_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(filt_en_i) |-> (!bom_valid_o && !biv_irq_o));
endmodule

bind bom_filter bom_filter_chk u_chk (.*);

// File: tb/bom_filter_test.sv
module bom_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0, bit_vld = 1'b0, filt_en = 1'b1;
  logic       fifo_wr, rme, biv, bvalid;
  logic [7:0] fifo_data;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  bom_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_vld_i(bit_vld),
    .filt_en_i(filt_en), .fifo_wr_o(fifo_wr), .fifo_data_o(fifo_data),
    .rme_irq_o(rme), .biv_irq_o(biv), .bom_valid_o(bvalid)
  );

  // observed
  logic [7:0] got_q[$];
  int got_rme = 0, got_biv = 0;
  // model
  logic [7:0] exp_q[$];
  int exp_rme = 0, exp_biv = 0;
  int win[10];
  bit m_valid = 0;
  int m_vcode = 0;

  always @(negedge clk) if (rst_n) begin
    if (fifo_wr) got_q.push_back(fifo_data);
    if (rme) got_rme++;
    if (biv) got_biv++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  task automatic m_write(input int code);
    exp_q.push_back(8'hFF);
    exp_q.push_back({1'b0, 6'(code), 1'b0});
    exp_q.push_back(8'h01);
    exp_rme++;
  endtask

  // model of one slot event; miss = bad close or sync-less run
  task automatic m_step(input bit miss, input int code);
    int nh, rh;
    bit held;
    for (int i = 9; i > 0; i--) win[i] = win[i-1];
    win[0] = miss ? -1 : code;
    if (!filt_en) begin
      m_valid = 0;
      if (!miss) m_write(code);
      return;
    end
    nh = 0; rh = 0;
    for (int i = 0; i < 10; i++) begin
      if (!miss && win[i] == code) nh++;
      if (win[i] == m_vcode) rh++;
    end
    held = m_valid && rh >= 7;
    if (m_valid && !held) exp_biv++;
    if (!held && !miss && nh >= 7) begin
      m_valid = 1; m_vcode = code; m_write(code);
    end else if (m_valid && !held) m_valid = 0;
  endtask

  task automatic send_word(input logic [15:0] w, input bit gaps);
    for (int i = 15; i >= 0; i--) begin
      if (gaps && ($urandom % 5 == 0)) begin
        @(negedge clk); bit_vld = 1'b0;
      end
      @(negedge clk); bit_vld = 1'b1; bit_in = w[i];
    end
    @(negedge clk); bit_vld = 1'b0;
  endtask

  task automatic compare();
    repeat (5) @(negedge clk);
    chk(got_q.size() == exp_q.size(), "R3 byte count", got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        chk(got_q[i] == exp_q[i], "R2 byte value", got_q[i], exp_q[i]);
    chk(got_rme == exp_rme, "R4 rme count", got_rme, exp_rme);
    chk(got_biv == exp_biv, "R7 biv count", got_biv, exp_biv);
    chk(bvalid == m_valid, "R5 valid flag", bvalid, m_valid);
    got_q.delete(); exp_q.delete();
    got_rme = 0; got_biv = 0; exp_rme = 0; exp_biv = 0;
  endtask

  // kind: 0 good, 1 bad close, 2 idle zeros
  task automatic word(input int kind, input int code, input bit gaps);
    if (kind == 2) send_word(16'h0000, gaps);
    else send_word({8'hFF, 1'b0, 6'(code), kind == 1}, gaps);
    m_step(kind != 0, code);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int fav, r;
    void'($urandom(32'd4242));
    for (int i = 0; i < 10; i++) win[i] = -1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fifo_wr && !rme && !biv && !bvalid, "R1 reset outputs", {fifo_wr, rme, biv, bvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // six repeats: below threshold, no write (R3)
    for (int i = 0; i < 6; i++) word(0, 6'h2A, 0);
    // seventh repeat, timing of first byte (R10)
    send_word({8'hFF, 1'b0, 6'h2A, 1'b0}, 0);
    chk(!fifo_wr, "R10 no write one cycle after close", fifo_wr, 0);
    @(negedge clk);
    chk(fifo_wr && fifo_data == 8'hFF, "R10 first byte two cycles after close", fifo_data, 8'hFF);
    m_step(0, 6'h2A);
    compare();
    // held repeats: no rewrite (R6)
    for (int i = 0; i < 5; i++) word(0, 6'h2A, 1);
    // bad closing bits age the pattern out (R8, R7)
    for (int i = 0; i < 5; i++) word(1, 6'h2A, 1);
    // idle slots (R8)
    for (int i = 0; i < 3; i++) word(2, 0, 1);
    // filter off: every good word written (R9)
    filt_en = 1'b0;
    word(0, 6'h15, 1); word(0, 6'h3F, 1); word(1, 6'h01, 1); word(0, 6'h00, 1);
    filt_en = 1'b1;

    fav = 0;
    for (int n = 0; n < 260; n++) begin
      if (n % 40 == 0) fav = $urandom % 64;
      if (n == 130) filt_en = 1'b0;
      if (n == 165) filt_en = 1'b1;
      r = $urandom % 100;
      if (r < 70)      word(0, fav, 1);
      else if (r < 85) word(0, $urandom % 64, 1);
      else if (r < 93) word(1, fav, 1);
      else             word(2, 0, 1);
    end
    summary();
  end
endmodule